// File: doc/BRIEF.md
# Write-Through Configuration Frame Cache

This block sits between a read-modify-write engine that retunes lookup-table contents and the port of the device's configuration memory. Configuration data is moved in column groups: one group is a set of consecutive frames (four by default) named by the address of its first frame. Reading a group out of configuration memory is slow. The cache keeps local copies of groups that were already read or written, so a later retune of the same column gets its data from local storage and never touches the memory read path.

A requester issues one request per group, either a read or a write, keyed by the base frame address. A read that hits streams the stored words out in ascending order, on the same valid/last interface as a memory read, so the requester cannot tell a hit from a miss except by latency. A read that misses issues one memory read and forwards the returned words while filling a cache entry. A write always goes through to memory word by word and also updates (or allocates) the cache entry, so the cached copy always equals the live configuration. Victims are chosen from empty entries first and then round-robin. A flush input empties the cache, and a pair of counters records lookups that hit and lookups that miss.

Real devices use 101-word frames and around 14 entries (about 23 KB of storage); the defaults are kept small and both are parameters.

Top module: `frame_cache`

## Requirements
- R1: After reset req_ready_o is 1, rd_valid_o, rd_last_o, mem_rd_o and mem_wvalid_o are 0, and both counters are 0.
- R2: A read request for an address not in the cache raises mem_rd_o for exactly one cycle with mem_addr_o equal to the request address, then forwards the FRAMES*FRAME_WORDS words arriving on mem_rvalid_i/mem_rdata_i to rd_valid_o/rd_data_o in arrival order.
- R3: A read request for a cached address returns the cached words in ascending word order (word 0 first) on rd_valid_o/rd_data_o and never raises mem_rd_o.
- R4: A write request forwards each word accepted on wr_valid_i to memory on mem_wvalid_o with its word index on mem_widx_o (0 upward) and mem_addr_o equal to the request address, issues no memory read, and a later read of that address returns the written words from the cache.
- R5: A write request to an address not in the cache allocates an entry, so a following read of that address is a hit.
- R6: flush_i asserted while idle invalidates every entry; the next read of any previously cached address misses.
- R7: On a miss the victim is the lowest-numbered invalid entry; when all entries are valid it is the entry at a round-robin pointer that starts at 0 after reset, advances by one (wrapping) on each such replacement and is not changed by flush. An address is never held by two entries.
- R8: Each accepted request, read or write, increments exactly one of hit_cnt_o (address was cached) or miss_cnt_o (it was not).
- R9: req_ready_o is 0 while a request is in progress and in any cycle where flush_i is 1.
- R10: rd_last_o is 1 together with the final word of each read stream and 0 for all other words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries (honoured while idle) |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high with req_valid_i |
| req_write_i | input | 1 | 1 = write group, 0 = read group |
| req_addr_i | input | ADDR_W | Base frame address of the group |
| wr_valid_i | input | 1 | Write word present |
| wr_data_i | input | DATA_W | Write word |
| rd_valid_o | output | 1 | Read word present |
| rd_data_o | output | DATA_W | Read word |
| rd_last_o | output | 1 | Final word of a read |
| mem_rd_o | output | 1 | One-cycle group read command to memory |
| mem_addr_o | output | ADDR_W | Base frame address for memory |
| mem_rvalid_i | input | 1 | Memory read word present |
| mem_rdata_i | input | DATA_W | Memory read word |
| mem_wvalid_o | output | 1 | Memory write word present |
| mem_widx_o | output | clog2(FRAMES*FRAME_WORDS) | Word index within the group |
| mem_wdata_o | output | DATA_W | Memory write word |
| hit_cnt_o | output | CNT_W | Lookups that hit (saturating) |
| miss_cnt_o | output | CNT_W | Lookups that missed (saturating) |

## Verification
The hardest state to reach from the ports is a full cache in which the round-robin pointer has moved away from entry 0 while flushes and write allocations have reopened holes, because only then do the "lowest invalid first" and "round-robin" rules pick different victims. A directed sequence fills every entry from reset and walks new addresses past the wrap, and a seeded random mix of reads, writes and flushes over twice as many addresses as entries keeps eviction and reallocation frequent. Every read is compared against a bench memory image, and the absence of memory reads on hits is counted from the mem_rd_o pulses.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    FC_IDLE,
    FC_HIT,
    FC_FILL,
    FC_WR
  } fc_state_e;
endpackage

// File: rtl/fc_tag_store.sv
module fc_tag_store #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 4,
  parameter int ENT_W   = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic              hit_o,
  output logic [ENT_W-1:0]  hit_idx_o,
  output logic [ENT_W-1:0]  victim_o,
  input  logic              alloc_i,
  input  logic [ENT_W-1:0]  alloc_idx_i,
  input  logic              fill_i,
  input  logic [ENT_W-1:0]  fill_idx_i,
  input  logic [ADDR_W-1:0] fill_tag_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [ENT_W-1:0]   rr_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = valid_q[e] && (tag_q[e] == look_addr_i);
  end

  assign hit_o = |match;

  always_comb begin
    hit_idx_o = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (match[e]) hit_idx_o = ENT_W'(e);
  end

  // lowest invalid entry wins, else round-robin pointer
  always_comb begin
    victim_o = rr_q;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (!valid_q[e]) victim_o = ENT_W'(e);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rr_q    <= '0;
      for (int e = 0; e < ENTRIES; e++) tag_q[e] <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else begin
      if (alloc_i) begin
        valid_q[alloc_idx_i] <= 1'b0;
        if (&valid_q)
          rr_q <= (rr_q == ENT_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
      if (fill_i) begin
        valid_q[fill_idx_i] <= 1'b1;
        tag_q[fill_idx_i]   <= fill_tag_i;
      end
    end
  end

  // R7
  uniq_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  // R6
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);

endmodule

// File: rtl/fc_data_ram.sv
module fc_data_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fc_event_ctr.sv
module fc_event_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (inc_i && !(&cnt_o)) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/frame_cache.sv
module frame_cache
  import fc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int FRAME_WORDS = 2,
  parameter int FRAMES      = 4,
  parameter int ENTRIES     = 4,
  parameter int CNT_W       = 16,
  localparam int GROUP_WORDS = FRAMES * FRAME_WORDS,
  localparam int WIDX_W      = $clog2(GROUP_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_wvalid_o,
  output logic [WIDX_W-1:0] mem_widx_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int ENT_W     = $clog2(ENTRIES);
  localparam int RAM_DEPTH = ENTRIES * GROUP_WORDS;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);

  fc_state_e         state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [ENT_W-1:0]  cur_ent_q;
  logic [WIDX_W-1:0] cnt_q;

  logic              hit;
  logic [ENT_W-1:0]  hit_idx, victim;
  logic              accept, last_word;
  logic              ram_we, fill_done;
  logic [RAM_AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  assign req_ready_o = (state_q == FC_IDLE) && !flush_i;
  assign accept      = req_valid_i && req_ready_o;
  assign last_word   = (cnt_q == WIDX_W'(GROUP_WORDS - 1));
  assign ram_addr    = RAM_AW'(cur_ent_q) * RAM_AW'(GROUP_WORDS) + RAM_AW'(cnt_q);
  assign ram_we      = ((state_q == FC_FILL) && mem_rvalid_i) ||
                       ((state_q == FC_WR) && wr_valid_i);
  assign ram_wdata   = (state_q == FC_WR) ? wr_data_i : mem_rdata_i;
  assign fill_done   = ram_we && last_word;

  fc_tag_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .ENT_W(ENT_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i && (state_q == FC_IDLE)),
    .look_addr_i (req_addr_i),
    .hit_o       (hit),
    .hit_idx_o   (hit_idx),
    .victim_o    (victim),
    .alloc_i     (accept && !hit),
    .alloc_idx_i (victim),
    .fill_i      (fill_done),
    .fill_idx_i  (cur_ent_q),
    .fill_tag_i  (cur_addr_q)
  );

  fc_data_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_addr),
    .wdata_i (ram_wdata),
    .raddr_i (ram_addr),
    .rdata_o (ram_rdata)
  );

  fc_event_ctr #(.CNT_W(CNT_W)) u_hit_ctr (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (accept && hit), .cnt_o (hit_cnt_o)
  );

  fc_event_ctr #(.CNT_W(CNT_W)) u_miss_ctr (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (accept && !hit), .cnt_o (miss_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= FC_IDLE;
      cur_addr_q   <= '0;
      cur_ent_q    <= '0;
      cnt_q        <= '0;
      rd_valid_o   <= 1'b0;
      rd_data_o    <= '0;
      rd_last_o    <= 1'b0;
      mem_rd_o     <= 1'b0;
      mem_addr_o   <= '0;
      mem_wvalid_o <= 1'b0;
      mem_widx_o   <= '0;
      mem_wdata_o  <= '0;
    end else begin
      rd_valid_o   <= 1'b0;
      rd_last_o    <= 1'b0;
      mem_rd_o     <= 1'b0;
      mem_wvalid_o <= 1'b0;
      unique case (state_q)
        FC_IDLE: if (accept) begin
          cur_addr_q <= req_addr_i;
          mem_addr_o <= req_addr_i;
          cur_ent_q  <= hit ? hit_idx : victim;
          cnt_q      <= '0;
          if (req_write_i) state_q <= FC_WR;
          else if (hit)    state_q <= FC_HIT;
          else begin
            state_q  <= FC_FILL;
            mem_rd_o <= 1'b1;
          end
        end
        FC_HIT: begin
          rd_valid_o <= 1'b1;
          rd_data_o  <= ram_rdata;
          rd_last_o  <= last_word;
          cnt_q      <= last_word ? '0 : cnt_q + 1'b1;
          if (last_word) state_q <= FC_IDLE;
        end
        FC_FILL: if (mem_rvalid_i) begin
          rd_valid_o <= 1'b1;
          rd_data_o  <= mem_rdata_i;
          rd_last_o  <= last_word;
          cnt_q      <= last_word ? '0 : cnt_q + 1'b1;
          if (last_word) state_q <= FC_IDLE;
        end
        FC_WR: if (wr_valid_i) begin
          mem_wvalid_o <= 1'b1;
          mem_wdata_o  <= wr_data_i;
          mem_widx_o   <= cnt_q;
          cnt_q        <= last_word ? '0 : cnt_q + 1'b1;
          if (last_word) state_q <= FC_IDLE;
        end
        default: state_q <= FC_IDLE;
      endcase
    end
  end

  // R3
  hit_no_mem_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FC_HIT) |-> !mem_rd_o);

  // R2
  mem_rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  // R10
  last_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);

  // R8
  one_ctr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt_o != $past(hit_cnt_o)) |-> (miss_cnt_o == $past(miss_cnt_o)));

  // R4
  wr_no_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wvalid_o |-> !rd_valid_o);

endmodule

// File: tb/frame_cache_tb.sv
module frame_cache_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int FW     = 2;
  localparam int FR     = 4;
  localparam int GW     = FW * FR;
  localparam int WIDX_W = $clog2(GW);
  localparam int ENT    = 4;
  localparam int CNT_W  = 16;
  localparam int NADDR  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              flush_i = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic              req_write_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic              wr_valid_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              rd_valid_o, rd_last_o;
  logic [DATA_W-1:0] rd_data_o;
  logic              mem_rd_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_rvalid_i = 1'b0;
  logic [DATA_W-1:0] mem_rdata_i = '0;
  logic              mem_wvalid_o;
  logic [WIDX_W-1:0] mem_widx_o;
  logic [DATA_W-1:0] mem_wdata_o;
  logic [CNT_W-1:0]  hit_cnt_o, miss_cnt_o;

  frame_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_WORDS(FW), .FRAMES(FR),
                .ENTRIES(ENT), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_last_o(rd_last_o),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .mem_wvalid_o(mem_wvalid_o), .mem_widx_o(mem_widx_o),
    .mem_wdata_o(mem_wdata_o), .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
  );

  int n_chk = 0;
  int n_err = 0;

  // bench images: memory as written by the DUT, and intended contents
  logic [DATA_W-1:0] mem_arr [NADDR][GW];
  logic [DATA_W-1:0] exp_arr [NADDR][GW];
  logic [DATA_W-1:0] got[$];
  int last_pos;
  int rd_pulses = 0;
  int wr_words = 0;
  logic [ADDR_W-1:0] last_rd_addr;
  logic [ADDR_W-1:0] last_wr_addr;
  int widx_bad = 0;

  // reference cache model
  bit     m_valid [ENT];
  int     m_tag   [ENT];
  int     m_rr = 0;
  int     m_hits = 0;
  int     m_miss = 0;

  function automatic logic [ADDR_W-1:0] addr_of(int k);
    return ADDR_W'(16 + 4 * k);
  endfunction

  function automatic int k_of(logic [ADDR_W-1:0] a);
    return (int'(a) - 16) / 4;
  endfunction

  function automatic bit model_access(int k);
    int v;
    for (int e = 0; e < ENT; e++)
      if (m_valid[e] && m_tag[e] == k) begin
        m_hits++;
        return 1'b1;
      end
    m_miss++;
    v = -1;
    for (int e = ENT - 1; e >= 0; e--) if (!m_valid[e]) v = e;
    if (v < 0) begin
      v = m_rr;
      m_rr = (m_rr + 1) % ENT;
    end
    m_valid[v] = 1'b1;
    m_tag[v]   = k;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor
  int wexp_idx = 0;
  initial forever begin
    @(negedge clk);
    if (mem_rd_o) begin
      rd_pulses++;
      last_rd_addr = mem_addr_o;
    end
    if (mem_wvalid_o) begin
      if (int'(mem_widx_o) != wexp_idx) widx_bad++;
      wexp_idx = (wexp_idx + 1) % GW;
      wr_words++;
      last_wr_addr = mem_addr_o;
      if (k_of(mem_addr_o) >= 0 && k_of(mem_addr_o) < NADDR)
        mem_arr[k_of(mem_addr_o)][mem_widx_o] = mem_wdata_o;
    end
    if (rd_valid_o) begin
      if (rd_last_o) last_pos = got.size();
      got.push_back(rd_data_o);
    end
  end

  // memory responder
  initial forever begin
    @(negedge clk);
    if (mem_rd_o) begin
      int kk;
      kk = k_of(mem_addr_o);
      repeat (2) @(negedge clk);
      for (int i = 0; i < GW; i++) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = (kk >= 0 && kk < NADDR) ? mem_arr[kk][i] : 32'hDEAD_BEEF;
        @(negedge clk);
        if ($urandom_range(0, 3) == 0) begin
          mem_rvalid_i = 1'b0;
          @(negedge clk);
        end
      end
      mem_rvalid_i = 1'b0;
    end
  end

  task automatic wait_ready();
    while (!req_ready_o) @(negedge clk);
  endtask

  task automatic do_read(input int k, input string tag);
    bit ph;
    int p0;
    ph = model_access(k);
    p0 = rd_pulses;
    got.delete();
    last_pos = -1;
    wait_ready();
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = addr_of(k);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R9 busy", 32'(req_ready_o), 0);
    while (got.size() < GW) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < GW; i++)
      chk(got[i] == exp_arr[k][i], ph ? "R3 data" : "R2 data", got[i], exp_arr[k][i]);
    chk(got.size() == GW, "R2/R3 count", 32'(got.size()), GW);
    chk(last_pos == GW - 1, "R10 last", 32'(last_pos), GW - 1);
    chk(rd_pulses - p0 == (ph ? 0 : 1), tag, 32'(rd_pulses - p0), ph ? 0 : 1);
    if (!ph) chk(last_rd_addr == addr_of(k), "R2 addr", 32'(last_rd_addr), 32'(addr_of(k)));
    chk(hit_cnt_o == CNT_W'(m_hits), "R8 hits", 32'(hit_cnt_o), m_hits);
    chk(miss_cnt_o == CNT_W'(m_miss), "R8 misses", 32'(miss_cnt_o), m_miss);
  endtask

  task automatic do_write(input int k, input string tag);
    bit ph;
    int p0, w0;
    logic [DATA_W-1:0] d;
    ph = model_access(k);
    p0 = rd_pulses;
    w0 = wr_words;
    wait_ready();
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = addr_of(k);
    @(negedge clk);
    req_valid_i = 1'b0;
    req_write_i = 1'b0;
    chk(req_ready_o == 1'b0, "R9 busy", 32'(req_ready_o), 0);
    for (int i = 0; i < GW; i++) begin
      d = $urandom;
      wr_valid_i = 1'b1;
      wr_data_i  = d;
      exp_arr[k][i] = d;
      @(negedge clk);
      wr_valid_i = 1'b0;
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < GW; i++)
      chk(mem_arr[k][i] == exp_arr[k][i], "R4 write-through", mem_arr[k][i], exp_arr[k][i]);
    chk(wr_words - w0 == GW, "R4 words", 32'(wr_words - w0), GW);
    chk(last_wr_addr == addr_of(k), "R4 addr", 32'(last_wr_addr), 32'(addr_of(k)));
    chk(widx_bad == 0, "R4 index order", 32'(widx_bad), 0);
    chk(rd_pulses == p0, tag, 32'(rd_pulses - p0), 0);
    chk(hit_cnt_o == CNT_W'(m_hits), "R8 hits", 32'(hit_cnt_o), m_hits);
    chk(miss_cnt_o == CNT_W'(m_miss), "R8 misses", 32'(miss_cnt_o), m_miss);
    if (ph) chk(1'b1, "R4 hit write", 0, 0);
  endtask

  task automatic do_flush();
    wait_ready();
    flush_i = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b0, "R9 flush", 32'(req_ready_o), 0);
    flush_i = 1'b0;
    for (int e = 0; e < ENT; e++) m_valid[e] = 1'b0;
    @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NADDR; k++)
      for (int i = 0; i < GW; i++) begin
        mem_arr[k][i] = 32'hC0DE_0000 ^ (32'(k) << 12) ^ (32'(i) * 32'h0101);
        exp_arr[k][i] = mem_arr[k][i];
      end
    for (int e = 0; e < ENT; e++) begin m_valid[e] = 1'b0; m_tag[e] = 0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1 ready", 32'(req_ready_o), 1);
    chk(!rd_valid_o && !rd_last_o, "R1 rd idle", 32'({rd_valid_o, rd_last_o}), 0);
    chk(!mem_rd_o && !mem_wvalid_o, "R1 mem idle", 32'({mem_rd_o, mem_wvalid_o}), 0);
    chk(hit_cnt_o == 0 && miss_cnt_o == 0, "R1 counters", 32'({hit_cnt_o, miss_cnt_o}), 0);

    do_read(0, "R2 miss read");
    do_read(0, "R3 hit no mem read");
    do_write(0, "R4 hit write no read");
    do_read(0, "R4 read after write");
    do_write(5, "R5 write miss no read");
    do_read(5, "R5 allocated hit");
    do_flush();
    do_read(0, "R6 miss after flush");
    do_read(5, "R6 miss after flush");
    do_flush();

    // R7 replacement walk from an empty cache with pointer at 0
    for (int k = 0; k < ENT; k++) do_read(k, "R7 fill");
    do_read(4, "R7 evict entry0");
    do_read(1, "R7 survivor hit");
    do_read(0, "R7 evicted miss");
    do_read(2, "R7 survivor hit");
    do_read(1, "R7 rr wraps on");
    do_write(6, "R7 write alloc");
    do_read(6, "R7 write alloc hit");

    // random mix
    for (int n = 0; n < 250; n++) begin
      int op, k;
      op = $urandom_range(0, 9);
      k  = $urandom_range(0, NADDR - 1);
      if (op == 0)      do_flush();
      else if (op <= 3) do_write(k, "R4 random write");
      else              do_read(k, "R7 random read");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule